// File: doc/BRIEF.md
# EDH Packet Flag Extractor

This block watches a parallel 10-bit standard-definition video word stream for error detection and handling (EDH) ancillary packets. A packet is recognised by the three-word ancillary data flag (000h, 3FFh, 3FFh) immediately followed by the EDH data identifier. The block then walks the block-number word, the data-count word, the payload and the checksum. From the payload it takes three five-bit error flag groups: one for the ancillary data area, one for the active picture area and one for the full field area.

The three groups sit in one sticky status store that both fields share. Every packet that passes its checks overwrites the whole store, whichever field carried it. A packet that fails leaves the store as it was. Reading never changes the store, and neither does the absence of packets; only a synchronous reset clears it. While a packet is being received, an active-low indication is held low. Its rising edge tells the host that the store has just been committed and may safely be read. The host reads one group at a time through a registered select-and-strobe port.

Top module: `edh_flag_capture`

## Requirements
- R1: A synchronous active-low reset clears all three flag groups and the stored field bit to zero, drives `pkt_n` high and clears `rd_data` to zero.
- R2: A packet starts only when a valid word equal to 1F4h directly follows the valid words 000h, 3FFh, 3FFh. `pkt_n` goes low after the clock edge that accepts that identifier word. Any other identifier leaves `pkt_n` high and the flags unchanged.
- R3: After the identifier come one block-number word, one data-count word and then that many payload words, where the count is bits 7:0 of the data-count word. The ancillary, active-picture and full-field groups are bits 5:1 of payload words 6, 7 and 8, counting the first payload word as 0. Group bit 0 is word bit 1 (EDH), followed in order by EDA, IDH and IDA, and group bit 4 is word bit 5 (UES).
- R4: The checksum is the 9-bit wrap-around sum of bits 8:0 of the identifier, block-number, data-count and payload words. It is compared with bits 8:0 of the word that follows the payload. On a mismatch, no flag group changes.
- R5: A packet whose data count is below 9 cannot carry all three groups and leaves the flags unchanged, even when its checksum matches.
- R6: A packet that passes its checks writes all three groups at the clock edge that accepts its checksum word. `pkt_n` goes high after that same edge.
- R7: The flags are sticky. Reads, idle stretches and streams without packets leave them unchanged.
- R8: Field 1 and field 2 packets update the same store, and the later packet replaces the earlier one. Select 3 returns, in bit 0, the field input that was sampled with the identifier word of the last committed packet, with bits 4:1 zero.
- R9: Cycles with `word_vld` low are ignored. They do not advance packet parsing or ancillary-flag matching, and cannot end a packet.
- R10: When `rd_en` is high at a clock edge, `rd_data` loads the group chosen by `rd_sel` (0 ancillary, 1 active picture, 2 full field, 3 field bit), using the store contents from before that edge. When `rd_en` is low, `rd_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 10 | Video data word |
| word_vld | input | 1 | Qualifies `word_in` in this cycle |
| field_in | input | 1 | Current field indication (0 first, 1 second) |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 2 | Host read select |
| rd_data | output | 5 | Registered read data |
| pkt_n | output | 1 | Low while an EDH packet is being received |

## Verification
`pkt_n` responds one edge after the identifier word and one edge after the checksum word. The flag store changes at that same checksum edge. A read issued in the following cycle returns the new groups one edge later, and a read issued at the checksum edge itself still returns the old ones. The bench's reference model steps on the same posedge as the design, handles reads before packet completion, and is compared at every falling edge. Each output is therefore checked in exactly the cycle in which it is due, including gapped packets, failed checksums, short counts, wrong identifiers and a reset in mid-run.

// File: rtl/edh_pkg.sv
// Package: shared constants and types for the EDH flag extractor.
// Assumes 10-bit words; the flag group width is fixed at five bits.
package edh_pkg;
    localparam int FLAG_W   = 5;
    localparam int N_AREA   = 3;
    localparam int AREA_ANC = 0;
    localparam int AREA_AP  = 1;
    localparam int AREA_FF  = 2;

    typedef logic [FLAG_W-1:0] flag_grp_t;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_DBN,
        PS_DCNT,
        PS_DATA,
        PS_CSUM
    } pstate_t;
endpackage

// File: rtl/edh_adf_seek.sv
// Module: tracks the ancillary data flag (all-zero, all-one, all-one)
// across consecutive valid words. adf_seen is high while the last three
// valid words formed the flag. Assumes invalid cycles carry no word.
module edh_adf_seek #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    output logic              adf_seen
);
    localparam logic [WORD_W-1:0] W_ZERO = '0;
    localparam logic [WORD_W-1:0] W_ONES = '1;

    logic [1:0] stage_q;
    logic       is_zero;
    logic       is_ones;

    assign is_zero = (word_in == W_ZERO);
    assign is_ones = (word_in == W_ONES);

    // Advance the flag matcher on each valid word; a zero word restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 2'd0;
        end else if (word_vld) begin
            case (stage_q)
                2'd1:    stage_q <= is_ones ? 2'd2 : (is_zero ? 2'd1 : 2'd0);
                2'd2:    stage_q <= is_ones ? 2'd3 : (is_zero ? 2'd1 : 2'd0);
                default: stage_q <= is_zero ? 2'd1 : 2'd0;
            endcase
        end
    end

    assign adf_seen = (stage_q == 2'd3);
endmodule

// File: rtl/edh_pkt_parse.sv
// Module: walks one EDH packet from its identifier word to its checksum.
// It accumulates the 9-bit checksum and stages the three flag groups.
// At the checksum word it raises commit_vld for one cycle, with commit_ok
// showing whether the sum matched and the count was long enough.
// Assumes the identifier is accepted only while adf_seen is high.
module edh_pkt_parse
    import edh_pkg::*;
#(
    parameter int              WORD_W   = 10,
    parameter logic [WORD_W-1:0] DID_VAL = 10'h1F4,
    parameter int              ANC_IDX  = 6,
    parameter int              AP_IDX   = 7,
    parameter int              FF_IDX   = 8,
    parameter int              FLAG_LSB = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_vld,
    input  logic [WORD_W-1:0]       word_in,
    input  logic                    field_in,
    input  logic                    adf_seen,
    output logic                    busy,
    output logic                    commit_vld,
    output logic                    commit_ok,
    output logic                    commit_field,
    output flag_grp_t [N_AREA-1:0]  commit_flags
);
    localparam int SUM_W   = WORD_W - 1;
    localparam int CNT_W   = 8;
    localparam int MAX_POS = (ANC_IDX > AP_IDX)
                           ? ((ANC_IDX > FF_IDX) ? ANC_IDX : FF_IDX)
                           : ((AP_IDX > FF_IDX) ? AP_IDX : FF_IDX);
    localparam int MIN_DC  = MAX_POS + 1;
    localparam int AREA_POS [N_AREA] = '{ANC_IDX, AP_IDX, FF_IDX};

    pstate_t                state_q, state_d;
    logic [CNT_W-1:0]       dc_q;
    logic [CNT_W-1:0]       idx_q;
    logic [SUM_W-1:0]       sum_q;
    logic                   field_q;
    flag_grp_t [N_AREA-1:0] stage_q;
    logic                   start;
    logic                   last_data;

    assign start     = (state_q == PS_IDLE) && word_vld && adf_seen
                       && (word_in == DID_VAL);
    assign last_data = (idx_q == dc_q - 8'd1);

    // Next-state selection; only valid words move the parser.
    always_comb begin
        state_d = state_q;
        if (word_vld) begin
            case (state_q)
                PS_IDLE: if (start) state_d = PS_DBN;
                PS_DBN:  state_d = PS_DCNT;
                PS_DCNT: state_d = (word_in[CNT_W-1:0] == '0) ? PS_CSUM : PS_DATA;
                PS_DATA: if (last_data) state_d = PS_CSUM;
                PS_CSUM: state_d = PS_IDLE;
                default: state_d = PS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Checksum accumulation, data count, payload index and field latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_q    <= '0;
            idx_q   <= '0;
            sum_q   <= '0;
            field_q <= 1'b0;
        end else if (word_vld) begin
            case (state_q)
                PS_IDLE: begin
                    if (start) begin
                        sum_q   <= word_in[SUM_W-1:0];
                        field_q <= field_in;
                    end
                end
                PS_DBN: sum_q <= sum_q + word_in[SUM_W-1:0];
                PS_DCNT: begin
                    sum_q <= sum_q + word_in[SUM_W-1:0];
                    dc_q  <= word_in[CNT_W-1:0];
                    idx_q <= '0;
                end
                PS_DATA: begin
                    sum_q <= sum_q + word_in[SUM_W-1:0];
                    idx_q <= idx_q + 8'd1;
                end
                default: ;
            endcase
        end
    end

    // One staging register per area, loaded at that area's payload position.
    for (genvar g = 0; g < N_AREA; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (word_vld && (state_q == PS_DATA)
                         && (idx_q == CNT_W'(AREA_POS[g]))) begin
                stage_q[g] <= word_in[FLAG_LSB +: FLAG_W];
            end
        end
    end

    assign busy         = (state_q != PS_IDLE);
    assign commit_vld   = (state_q == PS_CSUM) && word_vld;
    assign commit_ok    = (word_in[SUM_W-1:0] == sum_q) && (dc_q >= CNT_W'(MIN_DC));
    assign commit_field = field_q;
    assign commit_flags = stage_q;
endmodule

// File: rtl/edh_flag_bank.sv
// Module: sticky store for the three flag groups and the field bit, with
// a registered host read port. The store changes only on reset or on an
// accepted commit; reads have no side effects.
module edh_flag_bank
    import edh_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_vld,
    input  logic                    commit_ok,
    input  logic                    commit_field,
    input  flag_grp_t [N_AREA-1:0]  commit_flags,
    input  logic                    rd_en,
    input  logic [1:0]              rd_sel,
    output flag_grp_t [N_AREA-1:0]  flags_q,
    output logic [FLAG_W-1:0]       rd_data
);
    logic              field_q;
    logic [FLAG_W-1:0] rd_mux;

    // Sticky storage, one group per area, written together on a good packet.
    for (genvar g = 0; g < N_AREA; g++) begin : g_area
        always_ff @(posedge clk) begin
            if (!rst_n)                       flags_q[g] <= '0;
            else if (commit_vld && commit_ok) flags_q[g] <= commit_flags[g];
        end
    end

    // Field of the last committed packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                       field_q <= 1'b0;
        else if (commit_vld && commit_ok) field_q <= commit_field;
    end

    // Read select.
    always_comb begin
        case (rd_sel)
            2'd0:    rd_mux = flags_q[AREA_ANC];
            2'd1:    rd_mux = flags_q[AREA_AP];
            2'd2:    rd_mux = flags_q[AREA_FF];
            default: rd_mux = {{(FLAG_W-1){1'b0}}, field_q};
        endcase
    end

    // Registered read data, held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/edh_flag_capture.sv
// Module: top of the EDH flag extractor. Chains the flag matcher, the
// packet parser and the sticky flag store. pkt_n is low while a packet
// is in progress and rises at the edge where its flags are committed.
module edh_flag_capture
    import edh_pkg::*;
#(
    parameter int                WORD_W   = 10,
    parameter logic [WORD_W-1:0] DID_VAL  = 10'h1F4,
    parameter int                ANC_IDX  = 6,
    parameter int                AP_IDX   = 7,
    parameter int                FF_IDX   = 8,
    parameter int                FLAG_LSB = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_vld,
    input  logic              field_in,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [FLAG_W-1:0] rd_data,
    output logic              pkt_n
);
    logic                   adf_seen;
    logic                   busy;
    logic                   commit_vld;
    logic                   commit_ok;
    logic                   commit_field;
    flag_grp_t [N_AREA-1:0] commit_flags;
    flag_grp_t [N_AREA-1:0] bank_flags;

    edh_adf_seek #(.WORD_W(WORD_W)) u_seek (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word_in  (word_in),
        .adf_seen (adf_seen)
    );

    edh_pkt_parse #(
        .WORD_W   (WORD_W),
        .DID_VAL  (DID_VAL),
        .ANC_IDX  (ANC_IDX),
        .AP_IDX   (AP_IDX),
        .FF_IDX   (FF_IDX),
        .FLAG_LSB (FLAG_LSB)
    ) u_parse (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_vld     (word_vld),
        .word_in      (word_in),
        .field_in     (field_in),
        .adf_seen     (adf_seen),
        .busy         (busy),
        .commit_vld   (commit_vld),
        .commit_ok    (commit_ok),
        .commit_field (commit_field),
        .commit_flags (commit_flags)
    );

    edh_flag_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_vld   (commit_vld),
        .commit_ok    (commit_ok),
        .commit_field (commit_field),
        .commit_flags (commit_flags),
        .rd_en        (rd_en),
        .rd_sel       (rd_sel),
        .flags_q      (bank_flags),
        .rd_data      (rd_data)
    );

    assign pkt_n = ~busy;
endmodule

// File: rtl/edh_flag_capture_chk.sv
// Module: property checker for edh_flag_capture, attached by bind.
// Observes the top ports together with the parser-to-store commit path.
module edh_flag_capture_chk #(
    parameter int                WORD_W  = 10,
    parameter logic [WORD_W-1:0] DID_VAL = 10'h1F4,
    parameter int                FLAGS_W = 15,
    parameter int                RD_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               word_vld,
    input logic [WORD_W-1:0]  word_in,
    input logic               rd_en,
    input logic [RD_W-1:0]    rd_data,
    input logic               pkt_n,
    input logic               commit_vld,
    input logic               commit_ok,
    input logic [FLAGS_W-1:0] flags
);
    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_vld |=> $stable(flags));

    // R4
    bad_pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_vld && !commit_ok) |=> $stable(flags));

    // R2
    pkt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pkt_n) |-> $past(word_vld && (word_in == DID_VAL)));

    // R6
    pkt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_n) |-> $past(commit_vld));

    // R9
    stall_keeps_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_n && !word_vld) |=> !pkt_n);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind edh_flag_capture edh_flag_capture_chk #(
    .WORD_W  (WORD_W),
    .DID_VAL (DID_VAL),
    .FLAGS_W (edh_pkg::N_AREA * edh_pkg::FLAG_W),
    .RD_W    (edh_pkg::FLAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .word_in    (word_in),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .pkt_n      (pkt_n),
    .commit_vld (commit_vld),
    .commit_ok  (commit_ok),
    .flags      (bank_flags)
);

// File: tb/edh_flag_capture_test.sv
`timescale 1ns/1ps
module edh_flag_capture_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] word_in = '0;
    logic       word_vld = 1'b0;
    logic       field_in = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = '0;
    logic [4:0] rd_data;
    logic       pkt_n;

    int    vectors = 0;
    int    fails = 0;
    int    edges = 0;
    string req = "R1";

    always #4 clk = ~clk;

    edh_flag_capture uut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_vld(word_vld),
        .field_in(field_in), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .pkt_n(pkt_n)
    );

    // Behavioural reference model
    logic [9:0] hist[$];
    logic [9:0] pk[$];
    bit         in_pkt = 0;
    logic [4:0] m_fl[3] = '{5'd0, 5'd0, 5'd0};
    logic       m_fld = 1'b0;
    logic       m_pfld = 1'b0;
    logic [4:0] m_rd = 5'd0;

    always @(posedge clk) begin
        int n;
        int dc;
        logic [8:0] s;
        edges++;
        if (!rst_n) begin
            hist = {}; pk = {}; in_pkt = 0;
            m_fl = '{5'd0, 5'd0, 5'd0}; m_fld = 1'b0; m_rd = 5'd0;
        end else begin
            if (rd_en) m_rd = (rd_sel == 2'd3) ? {4'd0, m_fld} : m_fl[rd_sel];
            if (word_vld) begin
                if (in_pkt) begin
                    pk.push_back(word_in);
                    n = pk.size();
                    if (n >= 3) begin
                        dc = int'(pk[2][7:0]);
                        if (n == dc + 4) begin
                            s = 9'd0;
                            for (int i = 0; i < n - 1; i++) s = s + pk[i][8:0];
                            if (s == pk[n-1][8:0] && dc >= 9) begin
                                m_fl[0] = pk[9][5:1];
                                m_fl[1] = pk[10][5:1];
                                m_fl[2] = pk[11][5:1];
                                m_fld   = m_pfld;
                            end
                            in_pkt = 0;
                        end
                    end
                end else if (hist.size() == 3 && hist[0] == 10'h000 && hist[1] == 10'h3FF
                             && hist[2] == 10'h3FF && word_in == 10'h1F4) begin
                    in_pkt = 1;
                    pk = {word_in};
                    m_pfld = field_in;
                end
                hist.push_back(word_in);
                if (hist.size() > 3) void'(hist.pop_front());
            end
        end
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (edges > 0) begin
            vectors++;
            if (pkt_n !== !in_pkt) begin
                fails++;
                $display("FAIL %s pkt_n actual=%b expected=%b", req, pkt_n, !in_pkt);
            end
            vectors++;
            if (rd_data !== m_rd) begin
                fails++;
                $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, m_rd);
            end
        end
    end

    task automatic put(input logic v, input logic [9:0] w);
        word_vld = v; word_in = w;
        @(negedge clk);
        word_vld = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s);
        rd_en = 1'b1; rd_sel = s;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_all();
        for (int s = 0; s < 4; s++) rd(2'(s));
    endtask

    task automatic send_pkt(input logic fld, input logic [4:0] anc, input logic [4:0] ap,
                            input logic [4:0] ff, input int dc, input logic [9:0] did,
                            input bit bad, input bit gap);
        logic [9:0] q[$];
        logic [9:0] w;
        logic [8:0] s;
        field_in = fld;
        put(1, 10'h000); put(1, 10'h3FF); put(1, 10'h3FF);
        q = {did, 10'h200, {2'b01, 8'(dc)}};
        for (int i = 0; i < dc; i++) begin
            if (i == 6)      w = {4'd0, anc, 1'b0};
            else if (i == 7) w = {4'd0, ap, 1'b0};
            else if (i == 8) w = {4'd0, ff, 1'b0};
            else             w = 10'h100 | 10'((i * 37 + dc) & 8'hFF);
            q.push_back(w);
        end
        s = 9'd0;
        foreach (q[i]) s = s + q[i][8:0];
        w = {~s[8], s};
        if (bad) w = w ^ 10'h001;
        foreach (q[i]) begin
            put(1, q[i]);
            if (gap) put(0, 10'h000);
        end
        if (gap) put(0, 10'h3FF);
        put(1, w);
        put(0, 10'h000);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = "R1"; read_all();
        req = "R3"; send_pkt(1'b0, 5'h15, 5'h0A, 5'h1F, 16, 10'h1F4, 0, 0); read_all();
        req = "R6"; send_pkt(1'b0, 5'h01, 5'h02, 5'h04, 16, 10'h1F4, 0, 0);
        rd(2'd0); rd(2'd1); rd(2'd2);
        req = "R9"; send_pkt(1'b1, 5'h08, 5'h10, 5'h03, 16, 10'h1F4, 0, 1); read_all();
        req = "R4"; send_pkt(1'b0, 5'h1F, 5'h1F, 5'h1F, 16, 10'h1F4, 1, 0); read_all();
        req = "R5"; send_pkt(1'b0, 5'h11, 5'h11, 5'h11, 8, 10'h1F4, 0, 0); read_all();
        req = "R5"; send_pkt(1'b0, 5'h06, 5'h07, 5'h09, 9, 10'h1F4, 0, 0); read_all();
        req = "R2"; send_pkt(1'b1, 5'h1E, 5'h1D, 5'h1C, 16, 10'h1F5, 0, 0); read_all();
        req = "R7"; repeat (100) put(0, 10'h3FF);
        for (int i = 0; i < 50; i++) put(1, 10'(i * 13 + 5));
        read_all(); read_all();
        req = "R8"; send_pkt(1'b1, 5'h0C, 5'h0D, 5'h0E, 16, 10'h1F4, 0, 0); read_all();
        send_pkt(1'b0, 5'h12, 5'h13, 5'h14, 16, 10'h1F4, 0, 0); read_all();
        req = "R10"; rd_sel = 2'd1; repeat (5) @(negedge clk); rd_sel = 2'd2;
        repeat (5) @(negedge clk);
        req = "R2";
        for (int k = 0; k < 40; k++) begin
            int nz;
            nz = $urandom % 6;
            for (int j = 0; j < nz; j++) put($urandom % 2, 10'($urandom));
            send_pkt($urandom % 2, 5'($urandom), 5'($urandom), 5'($urandom),
                     (k % 3 == 0) ? 8 : ((k % 3 == 1) ? 9 : 16),
                     (k % 7 == 0) ? 10'h1F0 : 10'h1F4, ($urandom % 4) == 0, k % 2);
            rd(2'($urandom));
        end
        req = "R1"; rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
        read_all();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule